// File: doc/BRIEF.md
# Vector Floating-Point Exception Trap Sequencer

This block sits beside a vector floating-point datapath and handles the IEEE exception flags that come out of it. Elements of one instruction finish one after another. For each element the datapath presents five exception flags together with the element's index. The sequencer checks those flags against the trap-enable byte of the floating-point control register. It then decides one of two outcomes for the instruction: it traps with an element-tagged 8-bit code, or it completes, commits the destination and reports the combined flags.

A start pulse opens an instruction. It sets the element count from the size input and clears the flags collected so far. The first element whose enabled flags raise a trap ends the instruction at once. The trap code names that element and the highest-priority cause. Nothing is committed in that case, and the flag byte is left alone. Without a trap, the flags of all processed elements are ORed together. They are presented in the layout of the control register's flag byte, with a one-cycle update strobe and a commit strobe. In single-element mode only element 0 is processed.

Top module: `vfx_trap_seq`

## Requirements
- R1: On a trap, `trap_code_o` is the element index in bits 7:4 and the cause code in bits 3:0. It holds that value until the next start pulse, which clears it to 0.
- R2: Cause codes are invalid = 1, divide-by-zero = 2, overflow = 3, underflow = 4 and inexact = 5. When several enabled flags are raised, the lowest cause code wins. Element flag bits are invalid = bit 4, divide-by-zero = bit 3, overflow = bit 2, underflow = bit 1 and inexact = bit 0.
- R3: A flag traps only when its enable bit is set in `trap_en_i`: invalid = bit 7, divide-by-zero = bit 6, overflow = bit 5, underflow = bit 4 and inexact = bit 3. A flag without its enable bit never traps.
- R4: While `sup_inexact_i` is high, an enabled inexact flag never causes a trap.
- R5: A trap suppresses the instruction. `commit_o` and `flag_upd_o` stay low, `flag_bits_o` keeps its previous value, and further elements are ignored until the next start.
- R6: Without a trap, the last element raises `commit_o` and `flag_upd_o` for one cycle. `flag_bits_o` then carries the OR of the flags of all processed elements in bits 7:3, using the bit order of R3, with bits 2:0 zero.
- R7: `size_i` sets the number of elements per instruction: 0 gives 4 elements, 1 gives 2, and 2 or 3 gives 1.
- R8: While `single_i` is high, processing ends after the first element.
- R9: A start pulse clears the accumulated flags. An element presented in the same cycle as start is ignored.
- R10: `done_o` pulses for exactly one cycle, one cycle after the element that ends the instruction, together with either `trap_o` or `commit_o`.
- R11: After reset all strobes are low and `trap_code_o` and `flag_bits_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens an instruction and clears the accumulated flags |
| size_i | input | 2 | Element size select (0: 32-bit, 1: 64-bit, 2/3: 128-bit) |
| single_i | input | 1 | Single-element mode |
| sup_inexact_i | input | 1 | Inexact trap suppression |
| trap_en_i | input | 8 | Trap-enable byte of the control register |
| elem_valid_i | input | 1 | Element flags valid |
| elem_idx_i | input | 4 | Index of the finished element |
| elem_flags_i | input | 5 | Exception flags of the element |
| trap_o | output | 1 | Trap strobe |
| trap_code_o | output | 8 | Element-tagged trap code |
| flag_upd_o | output | 1 | Flag byte update strobe |
| flag_bits_o | output | 8 | Combined flags, control-register layout |
| commit_o | output | 1 | Destination write strobe |
| done_o | output | 1 | Instruction finished |

## Verification
The hardest situation to reach from the ports is a trap on a later element after earlier elements have already raised non-trapping flags. The trap must still leave the flag byte untouched, and any elements after it must be ignored. The stimulus first completes a clean instruction so that `flag_bits_o` holds a known non-zero value. It then feeds flags that are not enabled on early elements before a trapping one, and keeps sending elements afterwards. Priority is checked by raising several enabled flags at once. Suppression of inexact is checked by the same flags with the control toggled.

// File: rtl/vfx_pkg.sv
package vfx_pkg;
  localparam int NFLAG   = 5;
  localparam int CAUSE_W = 4;
  localparam int IDX_W   = 4;
  localparam int CODE_W  = IDX_W + CAUSE_W;
  localparam int BYTE_W  = 8;
  // flag bit positions inside an element flag vector
  localparam int FB_INV = 4;
  localparam int FB_DZ  = 3;
  localparam int FB_OVF = 2;
  localparam int FB_UNF = 1;
  localparam int FB_INX = 0;
  // flag byte of the control register: flags sit in bits 7:3
  localparam int FLAG_LSB = BYTE_W - NFLAG;
endpackage

// File: rtl/vfx_trap_prio.sv
module vfx_trap_prio
  import vfx_pkg::*;
(
  input  logic [NFLAG-1:0]   flags_i,
  input  logic [NFLAG-1:0]   en_i,
  input  logic               sup_inx_i,
  output logic               hit_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NFLAG-1:0] live;

  always_comb begin
    live = flags_i & en_i;
    if (sup_inx_i) live[FB_INX] = 1'b0;
  end

  // higher bit = higher priority = smaller cause code
  always_comb begin
    cause_o = '0;
    for (int i = 0; i < NFLAG; i++) begin
      if (live[i]) cause_o = CAUSE_W'(NFLAG - i);
    end
  end

  assign hit_o = |live;
endmodule

// File: rtl/vfx_elem_ctr.sv
module vfx_elem_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i || adv_i) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == limit_i - CNT_W'(1));
endmodule

// File: rtl/vfx_trap_seq.sv
module vfx_trap_seq
  import vfx_pkg::*;
#(
  parameter int MAX_ELEMS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         size_i,
  input  logic               single_i,
  input  logic               sup_inexact_i,
  input  logic [BYTE_W-1:0]  trap_en_i,
  input  logic               elem_valid_i,
  input  logic [IDX_W-1:0]   elem_idx_i,
  input  logic [NFLAG-1:0]   elem_flags_i,
  output logic               trap_o,
  output logic [CODE_W-1:0]  trap_code_o,
  output logic               flag_upd_o,
  output logic [BYTE_W-1:0]  flag_bits_o,
  output logic               commit_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(MAX_ELEMS + 1);

  logic               active_q, active_d;
  logic [CNT_W-1:0]   limit_q, limit_d, limit_sel;
  logic [NFLAG-1:0]   acc_q, acc_d, acc_now;
  logic [CODE_W-1:0]  code_q, code_d;
  logic [BYTE_W-1:0]  fbits_q, fbits_d;
  logic               trap_d, commit_d, done_d;
  logic               hit, last, take, adv;
  logic [CAUSE_W-1:0] cause;
  logic               unused_en;

  assign unused_en = ^trap_en_i[FLAG_LSB-1:0];

  vfx_trap_prio u_prio (
    .flags_i   (elem_flags_i),
    .en_i      (trap_en_i[BYTE_W-1:FLAG_LSB]),
    .sup_inx_i (sup_inexact_i),
    .hit_o     (hit),
    .cause_o   (cause)
  );

  assign take = active_q && elem_valid_i && !start_i;
  assign adv  = take && !hit;

  vfx_elem_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .adv_i   (adv),
    .limit_i (limit_q),
    .last_o  (last)
  );

  always_comb begin
    limit_sel = CNT_W'(MAX_ELEMS >> size_i);
    if (limit_sel == '0) limit_sel = CNT_W'(1);
  end

  assign acc_now = acc_q | elem_flags_i;

  always_comb begin
    active_d = active_q;
    limit_d  = limit_q;
    acc_d    = acc_q;
    code_d   = code_q;
    fbits_d  = fbits_q;
    trap_d   = 1'b0;
    commit_d = 1'b0;
    done_d   = 1'b0;
    if (start_i) begin
      active_d = 1'b1;
      limit_d  = limit_sel;
      acc_d    = '0;
      code_d   = '0;
    end else if (take) begin
      if (hit) begin
        trap_d   = 1'b1;
        done_d   = 1'b1;
        code_d   = {elem_idx_i, cause};
        active_d = 1'b0;
      end else begin
        acc_d = acc_now;
        if (single_i || last) begin
          commit_d = 1'b1;
          done_d   = 1'b1;
          fbits_d  = {acc_now, {FLAG_LSB{1'b0}}};
          active_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      limit_q     <= CNT_W'(1);
      acc_q       <= '0;
      code_q      <= '0;
      fbits_q     <= '0;
      trap_o      <= 1'b0;
      commit_o    <= 1'b0;
      flag_upd_o  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      active_q   <= active_d;
      limit_q    <= limit_d;
      acc_q      <= acc_d;
      code_q     <= code_d;
      fbits_q    <= fbits_d;
      trap_o     <= trap_d;
      commit_o   <= commit_d;
      flag_upd_o <= commit_d;
      done_o     <= done_d;
    end
  end

  assign trap_code_o = code_q;
  assign flag_bits_o = fbits_q;
endmodule

// File: rtl/vfx_trap_seq_chk.sv
module vfx_trap_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       elem_valid_i,
  input logic       sup_inexact_i,
  input logic       trap_o,
  input logic [7:0] trap_code_o,
  input logic       flag_upd_o,
  input logic [7:0] flag_bits_o,
  input logic       commit_o,
  input logic       done_o
);
  assert_trap_commit_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (!commit_o && !flag_upd_o));

  assert_trap_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $stable(flag_bits_o));

  assert_done_pairs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (trap_o || commit_o));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_code_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !elem_valid_i) |=> $stable(trap_code_o));

  assert_cause_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (trap_code_o[3:0] >= 4'd1 && trap_code_o[3:0] <= 4'd5));

  assert_no_inexact_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && $past(sup_inexact_i)) |-> (trap_code_o[3:0] != 4'd5));

  assert_flags_only_on_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_upd_o) |-> $stable(flag_bits_o));
endmodule

bind vfx_trap_seq vfx_trap_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .elem_valid_i  (elem_valid_i),
  .sup_inexact_i (sup_inexact_i),
  .trap_o        (trap_o),
  .trap_code_o   (trap_code_o),
  .flag_upd_o    (flag_upd_o),
  .flag_bits_o   (flag_bits_o),
  .commit_o      (commit_o),
  .done_o        (done_o)
);

// File: tb/tb_vfx_trap_seq.sv
module tb_vfx_trap_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i = 1'b0;
  logic [1:0] size_i = 2'd0;
  logic       single_i = 1'b0;
  logic       sup_inexact_i = 1'b0;
  logic [7:0] trap_en_i = 8'h00;
  logic       elem_valid_i = 1'b0;
  logic [3:0] elem_idx_i = 4'd0;
  logic [4:0] elem_flags_i = 5'd0;
  logic       trap_o, flag_upd_o, commit_o, done_o;
  logic [7:0] trap_code_o, flag_bits_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vfx_trap_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .single_i(single_i), .sup_inexact_i(sup_inexact_i), .trap_en_i(trap_en_i),
    .elem_valid_i(elem_valid_i), .elem_idx_i(elem_idx_i), .elem_flags_i(elem_flags_i),
    .trap_o(trap_o), .trap_code_o(trap_code_o), .flag_upd_o(flag_upd_o),
    .flag_bits_o(flag_bits_o), .commit_o(commit_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // packs strobes as {trap, commit, flag_upd, done}
  function automatic logic [3:0] strobes();
    return {trap_o, commit_o, flag_upd_o, done_o};
  endfunction

  task automatic begin_instr(input logic [1:0] sz, input logic sgl);
    @(negedge clk);
    start_i = 1'b1; size_i = sz; single_i = sgl;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [3:0] idx, input logic [4:0] fl);
    @(negedge clk);
    elem_valid_i = 1'b1; elem_idx_i = idx; elem_flags_i = fl;
    @(negedge clk);
    elem_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 strobes", 32'(strobes()), 32'h0);
    chk("R11 code", 32'(trap_code_o), 32'h0);
    chk("R11 flags", 32'(flag_bits_o), 32'h0);
  endtask

  task automatic t_clean_four();
    trap_en_i = 8'h00; sup_inexact_i = 1'b0;
    begin_instr(2'd0, 1'b0);
    send(4'd0, 5'b00001); chk("R7 not done e0", 32'(done_o), 32'h0);
    send(4'd1, 5'b00010); chk("R7 not done e1", 32'(done_o), 32'h0);
    send(4'd2, 5'b00000); chk("R7 not done e2", 32'(done_o), 32'h0);
    send(4'd3, 5'b00100);
    chk("R6 R10 strobes", 32'(strobes()), 32'b0111);
    chk("R6 flag byte", 32'(flag_bits_o), 32'h38);
    @(negedge clk);
    chk("R10 done one cycle", 32'(strobes()), 32'h0);
  endtask

  task automatic t_priority_all();
    trap_en_i = 8'hF8;
    begin_instr(2'd0, 1'b0);
    send(4'd0, 5'b11111);
    chk("R2 R1 R10 trap strobes", 32'(strobes()), 32'b1001);
    chk("R2 invalid first", 32'(trap_code_o), 32'h01);
    chk("R5 flags kept", 32'(flag_bits_o), 32'h38);
    send(4'd1, 5'b00000);
    chk("R5 later element ignored", 32'(strobes()), 32'h0);
    repeat (3) @(negedge clk);
    chk("R1 code held", 32'(trap_code_o), 32'h01);
  endtask

  task automatic t_enable_mask();
    trap_en_i = 8'h20;
    begin_instr(2'd0, 1'b0);
    chk("R1 start clears code", 32'(trap_code_o), 32'h0);
    send(4'd0, 5'b10000); chk("R3 unenabled invalid", 32'(strobes()), 32'h0);
    send(4'd1, 5'b00001); chk("R3 unenabled inexact", 32'(strobes()), 32'h0);
    send(4'd2, 5'b10100);
    chk("R3 overflow trap", 32'(trap_o), 32'h1);
    chk("R1 R3 code", 32'(trap_code_o), 32'h23);
    chk("R5 no commit", 32'(commit_o), 32'h0);
  endtask

  task automatic t_inexact_sup();
    trap_en_i = 8'h08; sup_inexact_i = 1'b1;
    begin_instr(2'd1, 1'b0);
    send(4'd0, 5'b00001);
    send(4'd1, 5'b00001);
    chk("R4 R7 commit", 32'(strobes()), 32'b0111);
    chk("R4 flag byte", 32'(flag_bits_o), 32'h08);
    sup_inexact_i = 1'b0;
    begin_instr(2'd1, 1'b0);
    send(4'd0, 5'b00000);
    send(4'd1, 5'b00001);
    chk("R4 unsuppressed trap", 32'(trap_o), 32'h1);
    chk("R2 inexact code", 32'(trap_code_o), 32'h15);
  endtask

  task automatic t_priority_pairs();
    trap_en_i = 8'hF8;
    begin_instr(2'd0, 1'b0);
    send(4'd0, 5'b01100);
    chk("R2 divzero over overflow", 32'(trap_code_o), 32'h02);
    begin_instr(2'd0, 1'b0);
    send(4'd0, 5'b00000);
    send(4'd1, 5'b00110);
    chk("R2 overflow over underflow", 32'(trap_code_o), 32'h13);
    begin_instr(2'd0, 1'b0);
    send(4'd0, 5'b00011);
    chk("R2 underflow over inexact", 32'(trap_code_o), 32'h04);
  endtask

  task automatic t_wide();
    trap_en_i = 8'h00;
    begin_instr(2'd2, 1'b0);
    send(4'd0, 5'b01000);
    chk("R7 one element", 32'(strobes()), 32'b0111);
    chk("R7 flag byte", 32'(flag_bits_o), 32'h40);
    begin_instr(2'd3, 1'b0);
    send(4'd0, 5'b00100);
    chk("R7 size3 one element", 32'(done_o), 32'h1);
  endtask

  task automatic t_single();
    trap_en_i = 8'h00;
    begin_instr(2'd0, 1'b1);
    send(4'd0, 5'b00010);
    chk("R8 single done", 32'(strobes()), 32'b0111);
    chk("R8 flag byte", 32'(flag_bits_o), 32'h10);
    single_i = 1'b0;
  endtask

  task automatic t_start_clear();
    trap_en_i = 8'h00;
    @(negedge clk);
    start_i = 1'b1; size_i = 2'd1;
    elem_valid_i = 1'b1; elem_idx_i = 4'd0; elem_flags_i = 5'b11111;
    @(negedge clk);
    start_i = 1'b0; elem_valid_i = 1'b0;
    chk("R9 same-cycle element ignored", 32'(done_o), 32'h0);
    send(4'd0, 5'b00000);
    send(4'd1, 5'b00000);
    chk("R9 commit", 32'(commit_o), 32'h1);
    chk("R9 flags cleared", 32'(flag_bits_o), 32'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_four();
    t_priority_all();
    t_enable_mask();
    t_inexact_sup();
    t_priority_pairs();
    t_wide();
    t_single();
    t_start_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule